// File: doc/BRIEF.md
# Addressed SPI Register-Access Slave

This block is the serial front end of a small port-expander register file. It listens on a mode-0 SPI bus, recognises its own frames, and turns each frame into single-cycle read or write strobes on a plain register port. Up to eight such slaves can sit behind one chip select. Each slave is told apart from the others only by a three-bit hardware address that is strapped on its pins.

A frame is carried within one chip-select assertion. It opens with a control byte, whose top nibble is a fixed device prefix, whose bits 3..1 carry the hardware address and whose bit 0 selects the direction. A register address byte follows, then any number of data bytes. Two configuration bits come from the register file's configuration register. One of them turns hardware-address matching on. The other stops the register pointer from advancing between data bytes. All SPI pins are oversampled by the system clock after a synchronizer chain.

Top module: `pexp_spi_slave`

## Requirements
- R1: While reset is held and just after it is released, spi_miso_oe, reg_wr_en and reg_rd_en are all 0.
- R2: The bus uses mode 0. Chip select is active low. MOSI is taken on the rising SCK edge, MSB first. MISO only changes after a falling SCK edge while it is driven.
- R3: The first byte of a frame is the control byte. Bits 7..4 must equal the device prefix (default 4'b0100), otherwise the whole frame is ignored. Bit 0 = 1 means read and bit 0 = 0 means write.
- R4: With cfg_addr_en = 1, a control byte whose bits 3..1 differ from strap_addr makes the block ignore the frame until chip select rises. spi_miso_oe stays 0 and no register strobe is issued.
- R5: With cfg_addr_en = 0, bits 3..1 of the control byte are not compared, so any address value is accepted.
- R6: In a write frame, the second byte is the register address. Each following data byte gives exactly one single-cycle reg_wr_en pulse carrying the current pointer on reg_addr and the byte on reg_wdata.
- R7: In a read frame, the byte at the pointer is requested with a one-cycle reg_rd_en and sampled from reg_rdata in that cycle. It is shifted out MSB first, starting at the falling edge that follows the last bit of the address byte. spi_miso_oe is 1 only during the data phase of a matched read.
- R8: With cfg_seq_off = 0, the pointer advances by one after each data byte, and it wraps from the top register address (default 0x0A) back to 0x00.
- R9: With cfg_seq_off = 1, the pointer stays on the register address for the whole frame.
- R10: A pointer above the top register address reads as 0x00 and issues no reg_rd_en. Writes to such a pointer issue no reg_wr_en. Beyond the top address the pointer simply counts up.
- R11: Raising chip select ends the frame at once. A partly shifted byte is dropped, and the next assertion starts again with a control byte.
- R12: reg_wr_en and reg_rd_en are never high in the same cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| strap_addr | input | 3 | Strapped hardware address |
| cfg_addr_en | input | 1 | Configuration bit: compare the hardware address |
| cfg_seq_off | input | 1 | Configuration bit: hold the pointer between data bytes |
| reg_addr | output | 8 | Register port address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid in the cycle of reg_rd_en |

## Verification
Completion of the last data byte and the release of chip select can arrive within one synchronized cycle of each other. The bench provokes this by raising spi_cs_n one system clock after the final rising SCK edge of a write. It judges the result by checking that its register model receives exactly one write with the right value. A second collision happens in reads: the prefetch for the next byte coincides with the pointer wrap. A burst read starting at the top address must return the top register followed by register 0.

// File: rtl/pexp_spi_pkg.sv
package pexp_spi_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W);

   typedef enum logic [1:0] {
      PH_CTRL = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } phase_t;

   // pointer step: hold, wrap at the top register, or plain count above it
   function automatic logic [BYTE_W-1:0] next_ptr(input logic [BYTE_W-1:0] p,
                                                  input logic [BYTE_W-1:0] top,
                                                  input logic hold);
      if (hold)
         return p;
      if (p == top)
         return '0;
      return p + 1'b1;
   endfunction

endpackage

// File: rtl/pexp_spi_sync.sv
module pexp_spi_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain <= {STAGES{RST_VAL[g]}};
         else
            chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/pexp_spi_frame.sv
module pexp_spi_frame
   import pexp_spi_pkg::*;
#(
   parameter int HW_ADDR_W = 3,
   parameter int PFX_W = BYTE_W - HW_ADDR_W - 1,
   parameter logic [PFX_W-1:0] DEV_PREFIX = 'b0100,
   parameter int MAX_REG_ADDR = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_act,
   input  logic                 sck_rise,
   input  logic                 mosi_s,
   input  logic [HW_ADDR_W-1:0] strap,
   input  logic                 addr_en,
   input  logic                 seq_off,
   output logic [BYTE_W-1:0]    reg_addr,
   output logic [BYTE_W-1:0]    reg_wdata,
   output logic                 reg_wr_en,
   output logic                 reg_rd_en,
   output logic                 load_zero,
   output logic                 read_phase
);

   localparam logic [BYTE_W-1:0] TOP = BYTE_W'(MAX_REG_ADDR);

   phase_t            phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sr;
   logic [BYTE_W-1:0] ptr;
   logic              is_read;

   logic [BYTE_W-1:0] byte_val;
   logic [BYTE_W-1:0] step_ptr;
   logic [BYTE_W-1:0] fetch_addr;
   logic              byte_done;
   logic              ctrl_hit;
   logic              fetch_now;

   always_comb begin
      byte_val   = {rx_sr, mosi_s};
      byte_done  = cs_act && sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
      ctrl_hit   = (byte_val[BYTE_W-1 -: PFX_W] == DEV_PREFIX) &&
                   (!addr_en || (byte_val[HW_ADDR_W:1] == strap));
      step_ptr   = next_ptr(ptr, TOP, seq_off);
      fetch_addr = (phase == PH_ADDR) ? byte_val : step_ptr;
      fetch_now  = byte_done && is_read && (phase == PH_ADDR || phase == PH_DATA);
   end

   assign read_phase = (phase == PH_DATA) && is_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CTRL;
         bit_cnt   <= '0;
         rx_sr     <= '0;
         ptr       <= '0;
         is_read   <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         load_zero <= 1'b0;
      end else begin
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         load_zero <= 1'b0;
         if (!cs_act) begin
            phase   <= PH_CTRL;
            bit_cnt <= '0;
         end else if (sck_rise) begin
            rx_sr   <= byte_val[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
               case (phase)
                  PH_CTRL: begin
                     phase   <= ctrl_hit ? PH_ADDR : PH_SKIP;
                     is_read <= byte_val[0];
                  end
                  PH_ADDR: begin
                     ptr   <= byte_val;
                     phase <= PH_DATA;
                  end
                  PH_DATA: begin
                     ptr <= step_ptr;
                     if (!is_read && (ptr <= TOP)) begin
                        reg_wr_en <= 1'b1;
                        reg_addr  <= ptr;
                        reg_wdata <= byte_val;
                     end
                  end
                  default: ;
               endcase
               if (fetch_now) begin
                  reg_addr <= fetch_addr;
                  if (fetch_addr <= TOP)
                     reg_rd_en <= 1'b1;
                  else
                     load_zero <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pexp_spi_txpath.sv
module pexp_spi_txpath
   import pexp_spi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_fall,
   input  logic              read_phase,
   input  logic              rd_en,
   input  logic              load_zero,
   input  logic [BYTE_W-1:0] rdata,
   output logic              miso
);

   logic [BYTE_W-1:0] hold;
   logic [BYTE_W-1:0] tx;
   logic              pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         tx      <= '0;
         pending <= 1'b0;
      end else if (!cs_act) begin
         tx      <= '0;
         pending <= 1'b0;
      end else begin
         if (sck_fall && read_phase) begin
            if (pending) begin
               tx      <= hold;
               pending <= 1'b0;
            end else begin
               tx <= {tx[BYTE_W-2:0], 1'b0};
            end
         end
         if (rd_en) begin
            hold    <= rdata;
            pending <= 1'b1;
         end else if (load_zero) begin
            hold    <= '0;
            pending <= 1'b1;
         end
      end
   end

   assign miso = tx[BYTE_W-1];

endmodule

// File: rtl/pexp_spi_slave.sv
module pexp_spi_slave
   import pexp_spi_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HW_ADDR_W = 3,
   parameter logic [BYTE_W-HW_ADDR_W-2:0] DEV_PREFIX = 'b0100,
   parameter int MAX_REG_ADDR = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sck,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   output logic                 spi_miso_oe,
   input  logic [HW_ADDR_W-1:0] strap_addr,
   input  logic                 cfg_addr_en,
   input  logic                 cfg_seq_off,
   output logic [BYTE_W-1:0]    reg_addr,
   output logic                 reg_wr_en,
   output logic [BYTE_W-1:0]    reg_wdata,
   output logic                 reg_rd_en,
   input  logic [BYTE_W-1:0]    reg_rdata
);

   localparam int PFX_W = BYTE_W - HW_ADDR_W - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PFX_W < 1) begin : g_bad_addr_w
      $error("HW_ADDR_W leaves no room for the device prefix");
   end
   if (MAX_REG_ADDR < 0 || MAX_REG_ADDR >= (1 << BYTE_W)) begin : g_bad_top
      $error("MAX_REG_ADDR must fit in the register address byte");
   end

   logic [2:0] pins_s;
   logic       sck_s, mosi_s, cs_act;
   logic       sck_prev, sck_rise, sck_fall;
   logic       load_zero, read_phase;

   pexp_spi_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .din ({spi_cs_n, spi_sck, spi_mosi}),
      .dout(pins_s)
   );

   assign cs_act = ~pins_s[2];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sck_prev <= 1'b0;
      else
         sck_prev <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_prev;
   assign sck_fall = ~sck_s & sck_prev;

   pexp_spi_frame #(
      .HW_ADDR_W   (HW_ADDR_W),
      .PFX_W       (PFX_W),
      .DEV_PREFIX  (DEV_PREFIX),
      .MAX_REG_ADDR(MAX_REG_ADDR)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sck_rise  (sck_rise),
      .mosi_s    (mosi_s),
      .strap     (strap_addr),
      .addr_en   (cfg_addr_en),
      .seq_off   (cfg_seq_off),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr_en (reg_wr_en),
      .reg_rd_en (reg_rd_en),
      .load_zero (load_zero),
      .read_phase(read_phase)
   );

   pexp_spi_txpath u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sck_fall  (sck_fall),
      .read_phase(read_phase),
      .rd_en     (reg_rd_en),
      .load_zero (load_zero),
      .rdata     (reg_rdata),
      .miso      (spi_miso)
   );

   assign spi_miso_oe = read_phase;

endmodule

// File: rtl/pexp_spi_slave_chk.sv
module pexp_spi_slave_chk #(
   parameter int MAX_REG_ADDR = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_act,
   input logic       sck_fall,
   input logic       miso,
   input logic       miso_oe,
   input logic       wr_en,
   input logic       rd_en,
   input logic [7:0] addr
);

   assert_strobe_excl_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));

   assert_wr_pulse_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   assert_rd_pulse_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   assert_wr_in_range_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (addr <= 8'(MAX_REG_ADDR)));

   assert_rd_in_range_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (addr <= 8'(MAX_REG_ADDR)));

   assert_oe_off_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso_oe);

   assert_miso_on_fall_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && $past(miso_oe) && !$past(sck_fall)) |-> $stable(miso));

endmodule

bind pexp_spi_slave pexp_spi_slave_chk #(.MAX_REG_ADDR(MAX_REG_ADDR)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_act  (cs_act),
   .sck_fall(sck_fall),
   .miso    (spi_miso),
   .miso_oe (spi_miso_oe),
   .wr_en   (reg_wr_en),
   .rd_en   (reg_rd_en),
   .addr    (reg_addr)
);

// File: tb/test_pexp_spi_slave.sv
`timescale 1ns/1ps
module test_pexp_spi_slave;

   localparam int HALF = 8;
   localparam int TOPA = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       cs_n = 1'b1;
   logic       mosi = 1'b0;
   logic       miso, miso_oe;
   logic [2:0] strap = 3'b101;
   logic       addr_en = 1'b1;
   logic       seq_off = 1'b0;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_wr_en, reg_rd_en;

   logic [7:0] mem [0:TOPA];
   int wr_cnt = 0;
   int rd_cnt = 0;
   int oe_cnt = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pexp_spi_slave i_pexp_spi_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sck    (sck),
      .spi_cs_n   (cs_n),
      .spi_mosi   (mosi),
      .spi_miso   (miso),
      .spi_miso_oe(miso_oe),
      .strap_addr (strap),
      .cfg_addr_en(addr_en),
      .cfg_seq_off(seq_off),
      .reg_addr   (reg_addr),
      .reg_wr_en  (reg_wr_en),
      .reg_wdata  (reg_wdata),
      .reg_rd_en  (reg_rd_en),
      .reg_rdata  (reg_rdata)
   );

   // register file model
   assign reg_rdata = (reg_addr <= 8'(TOPA)) ? mem[reg_addr] : 8'hA5;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= TOPA; i++) mem[i] <= 8'h80 + 8'(i);
      end else begin
         if (reg_wr_en) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt++;
         end
         if (reg_rd_en) rd_cnt++;
      end
   end

   always @(negedge clk) if (miso_oe) oe_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic spi_byte(input logic [7:0] b, input bit cut, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk) mosi = b[i];
         repeat (HALF) @(negedge clk);
         r[i] = miso;
         sck = 1'b1;
         if (cut && i == 0) begin
            @(negedge clk) cs_n = 1'b1;
         end
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] c, input logic [7:0] a, input int n,
                       input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                       input bit cut,
                       output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2);
      logic [7:0] junk;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_byte(c, 1'b0, junk);
      spi_byte(a, 1'b0, junk);
      if (n > 0) spi_byte(d0, cut && n == 1, r0);
      if (n > 1) spi_byte(d1, cut && n == 2, r1);
      if (n > 2) spi_byte(d2, cut && n == 3, r2);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (3 * HALF) @(negedge clk);
   endtask

   // vector: ctrl, addr, d0, d1, expected write count (two data bytes each)
   localparam logic [35:0] VEC [5] = '{
      {8'h4A, 8'h02, 8'h11, 8'h22, 4'd2},
      {8'h48, 8'h02, 8'hEE, 8'hEE, 4'd0},
      {8'h5A, 8'h03, 8'hEE, 8'hEE, 4'd0},
      {8'h4A, 8'h0A, 8'h33, 8'h44, 4'd2},
      {8'h4A, 8'h0C, 8'h55, 8'h66, 4'd0}
   };

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r0, r1, r2;
      int w0, rd0, oe0;
      repeat (4) @(negedge clk);
      chk("R1 reset oe", int'(miso_oe), 0);
      chk("R1 reset wr", int'(reg_wr_en), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 post-reset rd", int'(reg_rd_en), 0);
      chk("R1 post-reset oe", int'(miso_oe), 0);

      // R3 R4 R6 R8 R10: write vectors
      for (int k = 0; k < 5; k++) begin
         w0 = wr_cnt;
         xfer(VEC[k][35:28], VEC[k][27:20], 2, VEC[k][19:12], VEC[k][11:4], 8'h00, 1'b0, r0, r1, r2);
         chk($sformatf("R6 vector %0d write count", k), wr_cnt - w0, int'(VEC[k][3:0]));
      end
      chk("R6 mem[2]", int'(mem[2]), 'h11);
      chk("R8 mem[3] after increment", int'(mem[3]), 'h22);
      chk("R8 wrap mem[10]", int'(mem[10]), 'h33);
      chk("R8 wrap mem[0]", int'(mem[0]), 'h44);

      // R7 R2: burst read, MSB first
      oe0 = oe_cnt;
      xfer(8'h4B, 8'h02, 3, 8'h00, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R7 read byte0", int'(r0), 'h11);
      chk("R7 read byte1", int'(r1), 'h22);
      chk("R8 read byte2", int'(r2), 'h84);
      chk("R7 oe driven during read", int'(oe_cnt > oe0), 1);
      // R8: prefetch collides with wrap
      xfer(8'h4B, 8'h0A, 2, 8'h00, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R8 wrap read top", int'(r0), 'h33);
      chk("R8 wrap read zero", int'(r1), 'h44);

      // R4: mismatched read leaves MISO off
      oe0 = oe_cnt; rd0 = rd_cnt;
      xfer(8'h49, 8'h02, 2, 8'h00, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R4 mismatch oe", oe_cnt - oe0, 0);
      chk("R4 mismatch rd strobes", rd_cnt - rd0, 0);

      // R10: out-of-range read gives zero, no strobe
      rd0 = rd_cnt;
      xfer(8'h4B, 8'h0B, 2, 8'h00, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R10 oor read byte0", int'(r0), 0);
      chk("R10 oor read byte1", int'(r1), 0);
      chk("R10 oor rd strobes", rd_cnt - rd0, 0);

      // R5: address compare off
      addr_en = 1'b0;
      w0 = wr_cnt;
      xfer(8'h40, 8'h06, 1, 8'h77, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R5 any address accepted", wr_cnt - w0, 1);
      chk("R5 mem[6]", int'(mem[6]), 'h77);
      addr_en = 1'b1;

      // R9: pointer hold
      seq_off = 1'b1;
      w0 = wr_cnt;
      xfer(8'h4A, 8'h05, 2, 8'h01, 8'h02, 8'h00, 1'b0, r0, r1, r2);
      chk("R9 write count", wr_cnt - w0, 2);
      chk("R9 mem[5] last byte", int'(mem[5]), 'h02);
      chk("R9 mem[6] untouched", int'(mem[6]), 'h77);
      xfer(8'h4B, 8'h02, 2, 8'h00, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R9 read repeat0", int'(r0), 'h11);
      chk("R9 read repeat1", int'(r1), 'h11);
      seq_off = 1'b0;

      // R11: abort in mid byte
      w0 = wr_cnt;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_byte(8'h4A, 1'b0, r0);
      spi_byte(8'h07, 1'b0, r0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk) mosi = 1'b1;
         repeat (HALF) @(negedge clk) sck = 1'b1;
         repeat (HALF) @(negedge clk) sck = 1'b0;
      end
      @(negedge clk) sck = 1'b0;
      cs_n = 1'b1;
      repeat (3 * HALF) @(negedge clk);
      chk("R11 aborted byte dropped", wr_cnt - w0, 0);
      xfer(8'h4A, 8'h07, 1, 8'h99, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R11 fresh frame count", wr_cnt - w0, 1);
      chk("R11 fresh frame mem[7]", int'(mem[7]), 'h99);

      // R6 R12: chip select released one clock after last rising edge
      w0 = wr_cnt;
      xfer(8'h4A, 8'h08, 1, 8'h5C, 8'h00, 8'h00, 1'b1, r0, r1, r2);
      chk("R12 late release count", wr_cnt - w0, 1);
      chk("R6 late release mem[8]", int'(mem[8]), 'h5C);

      // R3: bad prefix read stays silent
      oe0 = oe_cnt;
      xfer(8'h6B, 8'h02, 1, 8'h00, 8'h00, 8'h00, 1'b0, r0, r1, r2);
      chk("R3 bad prefix oe", oe_cnt - oe0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule